// File: doc/BRIEF.md
# Stored-Pattern Multi-Tone Sequencer

This block produces a set of square-wave note outputs without a divider per note. Each note's waveform is precomputed into a pattern memory in which one bit of every word holds one note's next level. An address counter steps through the memory, and the word read out at each step drives all of that memory's notes together.

The notes are split into groups. Each group has its own counter and its own pattern store. A group's counter runs over a cycle whose length is the least common multiple of the periods of that group's notes, so every note in the group repeats without a seam. Splitting the notes keeps each store far smaller than one table over all notes would be. Put notes whose periods share factors in the same group.

The pattern contents are computed from the per-note periods when the design is elaborated. A run enable freezes every counter and output in place.

Top module: `tone_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, every group counter is set to step 0 and every note output is driven low.
- R2: On each rising edge with `run` high and `rst` low, each group's step counter advances by exactly one. After step L-1 it returns to 0, where L is the least common multiple of the periods of the notes in that group. No step is skipped or repeated.
- R3: A note with period P (P of at least 2) has pattern value 1 at step k when (k mod P) < floor(P/2), and 0 otherwise.
- R4: The note outputs are registered. An enabled edge loads every note with its pattern value at the step its group held before that edge. The first enabled edge after reset therefore drives all notes high.
- R5: An edge with `run` low and `rst` low leaves every group counter and every note output unchanged.
- R6: Note i belongs to group i / NOTES_PER_GROUP, and its period is field i of `NOTE_PERIODS`, which occupies bits 16*i+15 down to 16*i. The groups step independently, each wrapping at its own length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Step enable; low freezes counters and outputs |
| notes | output | NUM_GROUPS*NOTES_PER_GROUP | Registered note levels, note i on bit i |

## Verification
The assertions check the counter on every cycle: it stays inside its cycle, advances by one or wraps to zero on an enabled edge, and holds when run is low. They also check that counters and pattern words start cleared when reset is released. Whether the stored bits form the right duty cycle for each period, and whether groups wrap at their own lengths, can only be seen by the bench. Its reference model counts steps per group, with a least common multiple it works out for itself, and compares all notes on every clock through long runs, freezes, run toggling and a reset taken in the middle of a run.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Largest number of notes one group may hold; periods are 16-bit fields.
  localparam int unsigned MAX_GROUP_NOTES = 16;
  localparam int unsigned PERIOD_BITS     = 16;
  localparam int unsigned PER_VEC_W       = MAX_GROUP_NOTES * PERIOD_BITS;

  function automatic int unsigned gcd_u(input int unsigned a_in, input int unsigned b_in);
    int unsigned a;
    int unsigned b;
    int unsigned t;
    a = a_in;
    b = b_in;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // Cycle length of a group: least common multiple of its note periods.
  function automatic int unsigned group_cycle(input logic [PER_VEC_W-1:0] per, input int unsigned n);
    int unsigned acc;
    int unsigned p;
    acc = 1;
    for (int unsigned i = 0; i < n; i++) begin
      p   = int'(per[i*PERIOD_BITS +: PERIOD_BITS]);
      acc = (acc / gcd_u(acc, p)) * p;
    end
    return acc;
  endfunction

  // Level of a note with period p at step k.
  function automatic logic tone_level(input int unsigned k, input int unsigned p);
    return ((k % p) < (p / 2)) ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/tone_step_counter.sv
module tone_step_counter #(
  parameter int unsigned CYCLE_LEN = 24,
  localparam int unsigned AW = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(CYCLE_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (en) begin
      if (addr == LAST) addr <= '0;
      else              addr <= addr + 1'b1;
    end
  end

  // R1: counter sits at step 0 once reset is released
  a_r1_counter_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (addr == '0));

  // R2: never leaves the group's cycle
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    addr <= LAST);

  // R2: single-step advance inside the cycle
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (en && addr != LAST) |=> (addr == AW'($past(addr) + 1'b1)));

  // R2: wrap to zero after the last step
  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && addr == LAST) |=> (addr == '0));

  // R5: frozen while disabled
  a_r5_hold_addr: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(addr));

endmodule

// File: rtl/tone_pattern_rom.sv
module tone_pattern_rom
  import tone_pkg::*;
#(
  parameter int unsigned NOTES     = 3,
  parameter int unsigned CYCLE_LEN = 24,
  parameter logic [PER_VEC_W-1:0] PERIODS = '0,
  localparam int unsigned AW = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [AW-1:0]    addr,
  output logic [NOTES-1:0] word
);

  logic [NOTES-1:0] mem [CYCLE_LEN];

  initial begin
    for (int unsigned k = 0; k < CYCLE_LEN; k++) begin
      for (int unsigned j = 0; j < NOTES; j++) begin
        mem[k][j] = tone_level(k, int'(PERIODS[j*PERIOD_BITS +: PERIOD_BITS]));
      end
    end
  end

  // Registered synchronous read with read enable: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (rst)     word <= '0;
    else if (en) word <= mem[addr];
  end

  // R1: outputs low when reset is released
  a_r1_word_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (word == '0));

  // R5: output frozen while disabled
  a_r5_hold_word: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(word));

endmodule

// File: rtl/tone_group.sv
module tone_group
  import tone_pkg::*;
#(
  parameter int unsigned NOTES = 3,
  parameter logic [PER_VEC_W-1:0] PERIODS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [NOTES-1:0] notes
);

  localparam int unsigned CYCLE_LEN = group_cycle(PERIODS, NOTES);
  localparam int unsigned AW = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;

  logic [AW-1:0] step;

  tone_step_counter #(.CYCLE_LEN(CYCLE_LEN)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .en   (run),
    .addr (step)
  );

  tone_pattern_rom #(
    .NOTES     (NOTES),
    .CYCLE_LEN (CYCLE_LEN),
    .PERIODS   (PERIODS)
  ) u_rom (
    .clk  (clk),
    .rst  (rst),
    .en   (run),
    .addr (step),
    .word (notes)
  );

endmodule

// File: rtl/tone_seq.sv
module tone_seq
  import tone_pkg::*;
#(
  parameter int unsigned NUM_GROUPS      = 2,
  parameter int unsigned NOTES_PER_GROUP = 3,
  localparam int unsigned NUM_NOTES      = NUM_GROUPS * NOTES_PER_GROUP,
  parameter logic [NUM_NOTES*16-1:0] NOTE_PERIODS =
    {16'd3, 16'd7, 16'd5, 16'd8, 16'd6, 16'd4}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  output logic [NUM_NOTES-1:0] notes
);

  localparam int unsigned GW = NOTES_PER_GROUP * PERIOD_BITS;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [PER_VEC_W-1:0] GPER =
      PER_VEC_W'(NOTE_PERIODS[g*GW +: GW]);

    tone_group #(
      .NOTES   (NOTES_PER_GROUP),
      .PERIODS (GPER)
    ) u_grp (
      .clk   (clk),
      .rst   (rst),
      .run   (run),
      .notes (notes[g*NOTES_PER_GROUP +: NOTES_PER_GROUP])
    );
  end

endmodule

// File: tb/sim_tone_seq.sv
module sim_tone_seq;

  localparam int NG  = 2;
  localparam int NPG = 3;
  localparam int NN  = NG * NPG;
  localparam int PER [NN] = '{4, 6, 8, 5, 7, 3};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [NN-1:0] notes;

  int errors = 0;
  int checks = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tone_seq #(
    .NUM_GROUPS      (NG),
    .NOTES_PER_GROUP (NPG),
    .NOTE_PERIODS    ({16'd3, 16'd7, 16'd5, 16'd8, 16'd6, 16'd4})
  ) u0 (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .notes (notes)
  );

  function automatic int gcd_i(int a, int b);
    while (b != 0) begin
      int t;
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  int glen [NG];
  int gstep [NG];
  logic [NN-1:0] expv = '0;

  initial begin
    for (int g = 0; g < NG; g++) begin
      glen[g]  = 1;
      gstep[g] = 0;
      for (int j = 0; j < NPG; j++)
        glen[g] = glen[g] / gcd_i(glen[g], PER[g*NPG+j]) * PER[g*NPG+j];
    end
  end

  // Behavioural reference: per-group step count, wraps at its own length.
  always @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NG; g++) gstep[g] = 0;
      expv = '0;
    end else if (run) begin
      for (int i = 0; i < NN; i++)
        expv[i] = ((gstep[i/NPG] % PER[i]) < (PER[i] / 2));
      for (int g = 0; g < NG; g++) gstep[g] = (gstep[g] + 1) % glen[g];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [NN-1:0] act,
                     input logic [NN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (model_on && !done)
      chk(notes === expv, "R2 R3 R4 R6 model", notes, expv);
  end

  initial begin
    logic [NN-1:0] held;
    repeat (3) @(negedge clk);
    chk(notes === '0, "R1 reset", notes, '0);
    model_on = 1'b1;
    rst = 1'b0;
    run = 1'b1;
    @(negedge clk);
    chk(notes === '1, "R4 first step all high", notes, '1);
    repeat (24) @(negedge clk);
    // 25 edges: group0 back at step 0 output, group1 shows step 24
    chk(notes === 6'b100111, "R2 R6 group wrap", notes, 6'b100111);
    repeat (225) @(negedge clk);
    run = 1'b0;
    held = notes;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(notes === held, "R5 freeze", notes, held);
    end
    for (int i = 0; i < 40; i++) begin
      run = i[0];
      @(negedge clk);
    end
    run = 1'b1;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(notes === '0, "R1 mid-run reset", notes, '0);
    rst = 1'b0;
    repeat (120) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule